// File: doc/BRIEF.md
# Looping Word-Sequence Generator

This block holds a short sequence of parallel output words and replays it on a word-wide output. Software configures it through one bank of write-only registers that the upstream command decoder delivers as (bank, address, byte) writes. Only writes tagged with bank 1 reach the block. First, a load phase fills the sequence one word at a time through a single data register. Then an arm pulse starts the replay, which advances one word on every clock-enable strobe supplied from outside.

A replay covers the stored words from index 0 to the last stored index. It repeats a programmed number of times and then stops with a completion flag raised. If the repeat count is zero, the replay continues until software disables the block or re-enters the load phase. A per-bit enable mask gates the output: a masked-off bit reads 0 on the data output and is also reported inactive on a matching enable output, so that a pad can tristate it.

The controller has four states. IDLE is left for LOAD when the load bit is set, and for PLAY on an arm pulse if at least one word is stored. LOAD returns to IDLE when the load bit clears. PLAY goes to DONE on the strobe that emits the final word of the final pass. DONE returns to PLAY on a new arm pulse. From any state, a zero configuration value forces IDLE, and a set load bit forces LOAD. Both of these abort a replay in progress.

Top module: `pattern_gen`

## Requirements
- R1: After reset, pat_out and pat_oe are all zero, busy is 0 and done is 0.
- R2: A write takes effect only when wr_bank equals 1. The addresses are 8 (configuration), 9 (arm), 10 (sequence data), 12 (repeat count) and 13 (output mask).
- R3: Writing the configuration with bit 1 set enters load mode and resets the write index to 0. Each data write in load mode stores the byte at the write index and advances it. The sequence length is the number of words stored, capped at DEPTH, and writes beyond the cap are dropped.
- R4: A data write made while configuration bit 1 is clear changes neither the stored words nor the sequence length.
- R5: Writing arm bit 0 as 1 and then as 0 starts a replay on the second write. This happens only if the configuration is non-zero, bit 1 is clear and the length is non-zero. busy then reads 1 in the following cycle.
- R6: While busy, each cycle with tick high shows the next stored word (masked) on pat_out in the cycle after. Words come in index order 0 to length-1, and the index wraps to 0 after the last word.
- R7: With a repeat count N greater than 0, the strobe that emits the last word of pass N ends the replay. In the next cycle done is 1, busy is 0, and pat_out keeps that last word.
- R8: With a repeat count of 0, the replay wraps indefinitely and done stays 0.
- R9: pat_oe equals the mask register. Bits of pat_out whose mask bit is 0 read 0. A mask write is visible in the cycle after it.
- R10: Writing configuration value 0 brings busy, done and pat_out to 0 within two cycles of the write.
- R11: Setting configuration bit 1 during a replay aborts it: busy and pat_out read 0 within two cycles of the write.
- R12: During a replay, pat_out holds its value in cycles without tick.
- R13: An arm pulse while the stored length is zero does not start a replay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Replay step strobe, one word per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_bank | input | 2 | Bank tag of the write; only 1 is accepted |
| wr_addr | input | 4 | Register address |
| wr_data | input | DATA_W | Register write value |
| pat_out | output | DATA_W | Masked replay word |
| pat_oe | output | DATA_W | Per-bit output enable, equal to the mask |
| busy | output | 1 | Replay in progress |
| done | output | 1 | Finite replay has finished |

## Verification
A wrong read index shows as a wrong word on pat_out on the very next strobe, and the sequence tables let every position of every pass be compared. A wrong pass count or length shows up exactly at the end of a replay: done rises one strobe too early or too late, or the final word is not the expected one. A write index that fails to reset or to saturate corrupts the first or the last replayed word of the following run. A controller that ignores a disable or an abort is caught within two cycles, because busy or pat_out fails to clear.

// File: rtl/pg_pkg.sv
package pg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PLAY = 2'd2,
        ST_DONE = 2'd3
    } pg_state_t;

    localparam logic [1:0] PG_BANK   = 2'd1;
    localparam logic [3:0] ADR_CFG   = 4'd8;
    localparam logic [3:0] ADR_ARM   = 4'd9;
    localparam logic [3:0] ADR_DATA  = 4'd10;
    localparam logic [3:0] ADR_LOOPS = 4'd12;
    localparam logic [3:0] ADR_MASK  = 4'd13;
endpackage

// File: rtl/pg_regs.sv
module pg_regs
    import pg_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_bank,
    input  logic [3:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              en,
    output logic              load,
    output logic              load_start,
    output logic              data_we,
    output logic              start,
    output logic [DATA_W-1:0] loops,
    output logic [DATA_W-1:0] mask
);
    logic              sel;
    logic [DATA_W-1:0] cfg_q;
    logic              arm_q;

    assign sel        = wr_en && (wr_bank == PG_BANK);
    assign load_start = sel && (wr_addr == ADR_CFG) && wr_data[1];
    assign data_we    = sel && (wr_addr == ADR_DATA);
    assign start      = sel && (wr_addr == ADR_ARM) && !wr_data[0] && arm_q;
    assign en         = |cfg_q;
    assign load       = cfg_q[1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            arm_q <= 1'b0;
            loops <= '0;
            mask  <= '0;
        end else if (sel) begin
            unique case (wr_addr)
                ADR_CFG:   cfg_q <= wr_data;
                ADR_ARM:   arm_q <= wr_data[0];
                ADR_LOOPS: loops <= wr_data;
                ADR_MASK:  mask  <= wr_data;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/pg_mem.sv
module pg_mem #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load_start,
    input  logic                       load,
    input  logic                       data_we,
    input  logic [DATA_W-1:0]          data_val,
    input  logic [$clog2(DEPTH)-1:0]   rd_addr,
    output logic [DATA_W-1:0]          rd_data,
    output logic [$clog2(DEPTH+1)-1:0] len
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] FULL = PW'(DEPTH);

    logic [DATA_W-1:0] store [DEPTH];
    logic [PW-1:0]     wptr;
    logic              accept;

    assign accept  = data_we && load && (wptr < FULL);
    assign rd_data = store[rd_addr];
    assign len     = wptr;

    always_ff @(posedge clk) begin
        if (!rst_n)          wptr <= '0;
        else if (load_start) wptr <= '0;
        else if (accept)     wptr <= wptr + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (accept) store[wptr[AW-1:0]] <= data_val;
    end

    assert_depth_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && load && wptr == FULL) |=> (wptr == FULL));

    assert_ignore_unloaded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && !load) |=> $stable(wptr));
endmodule

// File: rtl/pg_seq.sv
module pg_seq
    import pg_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick,
    input  logic                       en,
    input  logic                       load,
    input  logic                       start,
    input  logic [$clog2(DEPTH+1)-1:0] len,
    input  logic [DATA_W-1:0]          loops,
    input  logic [DATA_W-1:0]          rd_data,
    output logic [$clog2(DEPTH)-1:0]   rd_addr,
    output logic [DATA_W-1:0]          pat_q,
    output logic                       busy,
    output logic                       done
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = $clog2(DEPTH + 1);

    pg_state_t         state, state_n;
    logic [AW-1:0]     rptr;
    logic [DATA_W-1:0] pass;
    logic [PW-1:0]     last_idx;
    logic              at_last, final_pass;

    assign last_idx   = len - 1'b1;
    assign at_last    = (PW'(rptr) == last_idx);
    assign final_pass = (loops != '0) && (pass == loops - 1'b1);
    assign rd_addr    = rptr;
    assign busy       = (state == ST_PLAY);
    assign done       = (state == ST_DONE);

    always_comb begin
        state_n = state;
        if (!en)       state_n = ST_IDLE;
        else if (load) state_n = ST_LOAD;
        else begin
            unique case (state)
                ST_IDLE, ST_DONE: if (start && len != '0) state_n = ST_PLAY;
                ST_LOAD:          state_n = ST_IDLE;
                ST_PLAY:          if (tick && at_last && final_pass) state_n = ST_DONE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr  <= '0;
            pass  <= '0;
            pat_q <= '0;
        end else if (state_n == ST_IDLE || state_n == ST_LOAD) begin
            rptr  <= '0;
            pass  <= '0;
            pat_q <= '0;
        end else if (state != ST_PLAY && state_n == ST_PLAY) begin
            rptr  <= '0;
            pass  <= '0;
            pat_q <= '0;
        end else if (state == ST_PLAY && tick) begin
            pat_q <= rd_data;
            if (at_last) begin
                rptr <= '0;
                if (!final_pass) pass <= pass + 1'b1;
            end else begin
                rptr <= rptr + 1'b1;
            end
        end
    end

    assert_step_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PLAY && tick && en && !load && !at_last) |=> (rptr == AW'($past(rptr) + 1'b1)));

    assert_disable_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!busy && !done && pat_q == '0));

    assert_load_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (en && load) |=> (state == ST_LOAD && pat_q == '0));

    assert_hold_no_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PLAY && !tick && en && !load) |=> $stable(pat_q));

    assert_empty_no_start_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && en && !load && len == '0) |=> (state == ST_IDLE));
endmodule

// File: rtl/pattern_gen.sv
module pattern_gen #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [1:0]        wr_bank,
    input  logic [3:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] pat_out,
    output logic [DATA_W-1:0] pat_oe,
    output logic              busy,
    output logic              done
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = $clog2(DEPTH + 1);

    logic              en, load, load_start, data_we, start;
    logic [DATA_W-1:0] loops, mask, rd_data, pat_q;
    logic [AW-1:0]     rd_addr;
    logic [PW-1:0]     len;

    pg_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank),
        .wr_addr(wr_addr), .wr_data(wr_data), .en(en), .load(load),
        .load_start(load_start), .data_we(data_we), .start(start),
        .loops(loops), .mask(mask)
    );

    pg_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
        .clk(clk), .rst_n(rst_n), .load_start(load_start), .load(load),
        .data_we(data_we), .data_val(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .len(len)
    );

    pg_seq #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .load(load),
        .start(start), .len(len), .loops(loops), .rd_data(rd_data),
        .rd_addr(rd_addr), .pat_q(pat_q), .busy(busy), .done(done)
    );

    assign pat_out = pat_q & mask;
    assign pat_oe  = mask;
endmodule

// File: tb/sim_pattern_gen.sv
module sim_pattern_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_bank = '0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] pat_out, pat_oe;
    logic       busy, done;

    int checks = 0;
    int fails  = 0;
    bit reported = 0;

    // {length, repeat count, mask, seed}
    localparam logic [31:0] VEC [5] = '{
        {8'd4, 8'd1, 8'hFF, 8'd1},
        {8'd5, 8'd2, 8'h0F, 8'd2},
        {8'd1, 8'd3, 8'hA5, 8'd3},
        {8'd7, 8'd1, 8'hF0, 8'd4},
        {8'd2, 8'd4, 8'hFF, 8'd5}
    };

    always #5 clk = ~clk;

    pattern_gen u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_bank(wr_bank),
        .wr_addr(wr_addr), .wr_data(wr_data), .pat_out(pat_out), .pat_oe(pat_oe),
        .busy(busy), .done(done)
    );

    function automatic logic [7:0] wv(int i, int s);
        return 8'(i * 37 + s * 11 + 5);
    endfunction

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] bank, logic [3:0] addr, logic [7:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_bank = bank; wr_addr = addr; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic step();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic load_words(int n, int s);
        wr(2'd1, 4'd8, 8'h03);
        for (int i = 0; i < n; i++) wr(2'd1, 4'd10, wv(i, s));
        wr(2'd1, 4'd8, 8'h01);
    endtask

    task automatic arm();
        wr(2'd1, 4'd9, 8'h01);
        wr(2'd1, 4'd9, 8'h00);
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", pat_out, 0);
        check("R1", pat_oe, 0);
        check("R1", {busy, done}, 0);

        // R13 arm with nothing stored
        wr(2'd1, 4'd8, 8'h01);
        arm();
        check("R13", busy, 0);
        step();
        check("R13", pat_out, 0);

        // table of replays: R3 R5 R6 R7 R9
        for (int v = 0; v < 5; v++) begin
            int n, l, s;
            logic [7:0] m;
            n = int'(VEC[v][31:24]); l = int'(VEC[v][23:16]);
            m = VEC[v][15:8];        s = int'(VEC[v][7:0]);
            load_words(n, s);
            wr(2'd1, 4'd12, 8'(l));
            wr(2'd1, 4'd13, m);
            arm();
            check("R5", busy, 1);
            for (int p = 0; p < l; p++)
                for (int i = 0; i < n; i++) begin
                    step();
                    check("R6", pat_out, wv(i, s) & m);
                end
            check("R7", {busy, done}, 2'b01);
            check("R9", pat_oe, m);
        end

        // R3 saturation at depth 16
        load_words(18, 9);
        wr(2'd1, 4'd12, 8'd1);
        wr(2'd1, 4'd13, 8'hFF);
        arm();
        for (int i = 0; i < 15; i++) step();
        check("R3", done, 0);
        step();
        check("R3", pat_out, wv(15, 9));
        check("R3", done, 1);

        // R4 data write outside load mode
        load_words(3, 6);
        wr(2'd1, 4'd10, 8'hEE);
        arm();
        for (int i = 0; i < 3; i++) begin
            step();
            check("R4", pat_out, wv(i, 6));
        end
        check("R4", done, 1);

        // R2 wrong bank ignored
        wr(2'd0, 4'd13, 8'h00);
        check("R2", pat_oe, 8'hFF);
        wr(2'd2, 4'd8, 8'h00);
        check("R2", done, 1);

        // R8 continuous replay
        wr(2'd1, 4'd12, 8'd0);
        arm();
        for (int i = 0; i < 9; i++) begin
            step();
            check("R8", pat_out, wv(i % 3, 6));
        end
        check("R8", {busy, done}, 2'b10);

        // R12 hold without tick
        repeat (3) @(negedge clk);
        check("R12", pat_out, wv(2, 6));

        // R9 mask change mid-replay
        wr(2'd1, 4'd13, 8'h0F);
        check("R9", pat_out, wv(2, 6) & 8'h0F);
        check("R9", pat_oe, 8'h0F);

        // R10 disable
        wr(2'd1, 4'd8, 8'h00);
        @(negedge clk);
        check("R10", {busy, done}, 0);
        check("R10", pat_out, 0);

        // R11 load abort
        wr(2'd1, 4'd8, 8'h01);
        arm();
        step();
        check("R11", busy, 1);
        wr(2'd1, 4'd8, 8'h03);
        @(negedge clk);
        check("R11", busy, 0);
        check("R11", pat_out, 0);

        report();
    end
endmodule